// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of small saturating counters. The row is chosen by a few low-order bits of the branch address, and the column by a shift register that records the outcomes of the most recent resolved branches. With `HIST_BITS` = m and `CTR_BITS` = n, each address row therefore owns 2^m counters of n bits. The pipeline uses the block in two ways:

- **Lookup.** The fetch stage presents a PC every cycle. It receives a taken or not-taken guess, together with the history value that chose the counter.
- **Resolve.** Once the branch resolves, the pipeline returns the PC, the history value it captured at lookup and the actual outcome. The block moves that same counter one step towards the outcome and shifts the outcome into the history register.

Target address prediction and history repair after a misprediction lie outside this block.

Top module: `corr_bpred`

## Requirements
- R1: After reset the history register holds zero, and every counter holds the weakly-not-taken value 2^(n-1)-1. Every lookup then predicts not taken.
- R2: The row of a PC is PC bits [ALIGN_BITS+IDX_BITS-1 : ALIGN_BITS]. Bits below and above that field do not affect which counter is used.
- R3: Within a row, the counter used for a lookup is the one whose column number equals the current history value. `pred_hist` presents that history value.
- R4: `pred_taken` is the most significant bit of the selected counter.
- R5: A taken resolve adds one to the counter and a not-taken resolve subtracts one. The counter saturates at 2^n-1 and at 0.
- R6: A resolve updates exactly one counter: the one in the row of `rs_pc` and the column given by `rs_hist`, even when `rs_hist` differs from the current history.
- R7: On a resolve, the history shifts left by one place. The outcome enters bit 0 (1 = taken) and the oldest bit is dropped.
- R8: A lookup in the same cycle as a resolve sees the counters and history as they were before that resolve.
- R9: In a cycle without a resolve, the history and all counters keep their values, whatever PC is looked up.
- R10: With m = 1 and n = 1, each row holds two 1-bit predictors chosen by the single history bit. The selected bit is the guess, and a resolve overwrites it with the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Guess for `lk_pc`: 1 = taken |
| pred_hist | output | HIST_BITS | History value that chose the counter; returned later with the resolve |
| rs_valid | input | 1 | A resolved branch is presented this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_hist | input | HIST_BITS | History captured when that branch was predicted |
| rs_taken | input | 1 | Actual outcome: 1 = taken |

## Verification
The main configuration (m = 2, n = 2, 16 rows) is swept so that every row and every history column is resolved several times with pseudo-random outcomes. The history handed back on each resolve is chosen independently of the live register, which separates updating the column that made the guess from updating the current column.

Directed runs push one counter past both saturation limits. Lookups use aliased addresses that differ only outside the row field, and some lookups hit the same counter that is being resolved in that cycle, so an early update would show. A second instance in the (1,1) configuration confirms that the history bit picks between two independent one-bit predictors.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Widest counter the helper functions handle.
  localparam int CW_MAX = 8;
  typedef logic [CW_MAX-1:0] ctr_word_t;

  // Largest value of a w-bit counter.
  function automatic ctr_word_t ctr_top(input int w);
    return ctr_word_t'((1 << w) - 1);
  endfunction

  // Weakly-not-taken value: just below the taken threshold.
  function automatic ctr_word_t ctr_weak_nt(input int w);
    return ctr_word_t'((1 << (w - 1)) - 1);
  endfunction

  // One saturating step of a w-bit counter towards the outcome.
  function automatic ctr_word_t ctr_step(input ctr_word_t v, input logic tk, input int w);
    if (tk) begin
      return (v == ctr_top(w)) ? v : v + 1'b1;
    end
    return (v == '0) ? v : v - 1'b1;
  endfunction

  // Direction encoded by a w-bit counter: its top bit.
  function automatic logic ctr_says_taken(input ctr_word_t v, input int w);
    return v[w-1];
  endfunction

endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
  parameter int HIST_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 shift_in,
  output logic [HIST_BITS-1:0] hist_o
);

  logic [HIST_BITS-1:0] hist_q;

  generate
    if (HIST_BITS == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= shift_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_BITS-2:0], shift_in};
      end
    end
  endgenerate

  assign hist_o = hist_q;

endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W       = 32,
  parameter int ALIGN_BITS = 2,
  parameter int IDX_BITS   = 4,
  parameter int HIST_BITS  = 2,
  localparam int SLOT_BITS = IDX_BITS + HIST_BITS,
  localparam int ROW_TOP   = ALIGN_BITS + IDX_BITS
) (
  input  logic [PC_W-1:0]      pc,
  input  logic [HIST_BITS-1:0] hist,
  output logic [SLOT_BITS-1:0] slot
);

  logic [IDX_BITS-1:0] row;

  assign row  = pc[ROW_TOP-1:ALIGN_BITS];
  assign slot = {row, hist};

  // Address bits outside the row field take no part in the index.
  generate
    if (ALIGN_BITS > 0) begin : g_lo
      logic unused_lo;
      assign unused_lo = ^pc[ALIGN_BITS-1:0];
    end
    if (ROW_TOP < PC_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^pc[PC_W-1:ROW_TOP];
    end
  endgenerate

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int SLOT_BITS = 6,
  parameter int CTR_BITS  = 2,
  localparam int NSLOT    = 1 << SLOT_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SLOT_BITS-1:0] rd_slot,
  output logic [CTR_BITS-1:0]  rd_ctr,
  input  logic [SLOT_BITS-1:0] up_slot,
  output logic [CTR_BITS-1:0]  up_old,
  input  logic                 wr_en,
  input  logic [CTR_BITS-1:0]  wr_data,
  output logic [NSLOT-1:0]     wr_sel_o
);

  localparam logic [CTR_BITS-1:0] WEAK_NT = CTR_BITS'(ctr_weak_nt(CTR_BITS));

  logic [NSLOT*CTR_BITS-1:0] flat;

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_cell
      logic [CTR_BITS-1:0] cell_q;

      assign wr_sel_o[i] = wr_en && (up_slot == SLOT_BITS'(i));

      always_ff @(posedge clk) begin
        if (!rst_n)         cell_q <= WEAK_NT;
        else if (wr_sel_o[i]) cell_q <= wr_data;
      end

      assign flat[i*CTR_BITS +: CTR_BITS] = cell_q;
    end
  endgenerate

  // Both read ports see the registered state, so a same-cycle write stays hidden.
  assign rd_ctr = flat[rd_slot*CTR_BITS +: CTR_BITS];
  assign up_old = flat[up_slot*CTR_BITS +: CTR_BITS];

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import bp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ALIGN_BITS = 2,
  parameter int IDX_BITS   = 4,
  parameter int HIST_BITS  = 2,
  parameter int CTR_BITS   = 2,
  localparam int SLOT_BITS = IDX_BITS + HIST_BITS,
  localparam int NSLOT     = 1 << SLOT_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      lk_pc,
  output logic                 pred_taken,
  output logic [HIST_BITS-1:0] pred_hist,
  input  logic                 rs_valid,
  input  logic [PC_W-1:0]      rs_pc,
  input  logic [HIST_BITS-1:0] rs_hist,
  input  logic                 rs_taken
);

  // Named internal events, also used by the bound checker.
  logic [HIST_BITS-1:0] hist_q;
  logic [SLOT_BITS-1:0] lk_slot;
  logic [SLOT_BITS-1:0] rs_slot;
  logic [CTR_BITS-1:0]  rd_ctr;
  logic [CTR_BITS-1:0]  up_old;
  logic [CTR_BITS-1:0]  up_new;
  logic [NSLOT-1:0]     wr_sel;

  bp_hist_reg #(.HIST_BITS(HIST_BITS)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (rs_valid),
    .shift_in (rs_taken),
    .hist_o   (hist_q)
  );

  bp_index #(
    .PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS)
  ) u_lk_idx (
    .pc   (lk_pc),
    .hist (hist_q),
    .slot (lk_slot)
  );

  bp_index #(
    .PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS)
  ) u_rs_idx (
    .pc   (rs_pc),
    .hist (rs_hist),
    .slot (rs_slot)
  );

  bp_ctr_table #(.SLOT_BITS(SLOT_BITS), .CTR_BITS(CTR_BITS)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_slot  (lk_slot),
    .rd_ctr   (rd_ctr),
    .up_slot  (rs_slot),
    .up_old   (up_old),
    .wr_en    (rs_valid),
    .wr_data  (up_new),
    .wr_sel_o (wr_sel)
  );

  assign up_new     = CTR_BITS'(ctr_step(ctr_word_t'(up_old), rs_taken, CTR_BITS));
  assign pred_taken = ctr_says_taken(ctr_word_t'(rd_ctr), CTR_BITS);
  assign pred_hist  = hist_q;

endmodule

// File: rtl/bp_chk.sv
module bp_chk #(
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  parameter int NSLOT     = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rs_valid,
  input logic                 rs_taken,
  input logic                 pred_taken,
  input logic [HIST_BITS-1:0] hist_q,
  input logic [CTR_BITS-1:0]  up_old,
  input logic [CTR_BITS-1:0]  up_new,
  input logic [NSLOT-1:0]     wr_sel
);

  localparam logic [CTR_BITS-1:0] TOP = '1;

  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (hist_q == '0) && !pred_taken);

  // R7
  hist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> hist_q[0] == $past(rs_taken));

  // R9
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(hist_q));

  // R5
  ctr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> (rs_taken ? (up_new >= up_old) : (up_new <= up_old)));

  // R5
  ctr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && up_old == TOP) |-> up_new == TOP);

  // R6
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $countones(wr_sel) == 1);

  // R9
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> wr_sel == '0);

endmodule

bind corr_bpred bp_chk #(
  .HIST_BITS(HIST_BITS), .CTR_BITS(CTR_BITS), .NSLOT(NSLOT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rs_valid   (rs_valid),
  .rs_taken   (rs_taken),
  .pred_taken (pred_taken),
  .hist_q     (hist_q),
  .up_old     (up_old),
  .up_new     (up_new),
  .wr_sel     (wr_sel)
);

// File: tb/sim_corr_bpred.sv
module sim_corr_bpred;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // Main configuration (m=2, n=2, 16 rows).
  logic [31:0] lk_pc = '0, rs_pc = '0;
  logic        rs_valid = 1'b0, rs_taken = 1'b0;
  logic [1:0]  rs_hist = '0;
  logic        pred_taken;
  logic [1:0]  pred_hist;

  corr_bpred u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .rs_valid(rs_valid), .rs_pc(rs_pc),
    .rs_hist(rs_hist), .rs_taken(rs_taken)
  );

  // (1,1) configuration.
  logic [31:0] lk1_pc = '0, rs1_pc = '0;
  logic        rs1_valid = 1'b0, rs1_taken = 1'b0;
  logic        rs1_hist = 1'b0;
  logic        pred1_taken;
  logic        pred1_hist;

  corr_bpred #(.HIST_BITS(1), .CTR_BITS(1)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk1_pc), .pred_taken(pred1_taken),
    .pred_hist(pred1_hist), .rs_valid(rs1_valid), .rs_pc(rs1_pc),
    .rs_hist(rs1_hist), .rs_taken(rs1_taken)
  );

  int n_chk = 0;
  int n_err = 0;
  int mdl [64];
  int ghr = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  function automatic int row_of(input logic [31:0] pc);
    return int'((pc >> 2) & 32'hF);
  endfunction

  function automatic logic [31:0] pc_of(input int row, input logic [31:0] noise);
    return (noise & 32'hFFFF_FFC3) | (32'(row) << 2);
  endfunction

  task automatic next_rand(output logic [31:0] r);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    r = lfsr;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle of the main instance; expectations come from the bench model.
  task automatic cyc(input logic [31:0] lpc, input logic rv, input logic [31:0] rpc,
                     input int rh, input logic rt, input string tag);
    int s;
    @(negedge clk);
    lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_hist = 2'(rh); rs_taken = rt;
    #1;
    check(tag, int'(pred_taken), (mdl[row_of(lpc)*4 + ghr] >= 2) ? 1 : 0);
    check("R7", int'(pred_hist), ghr);
    @(posedge clk);
    if (rv) begin
      s = row_of(rpc) * 4 + rh;
      if (rt) mdl[s] = (mdl[s] == 3) ? 3 : mdl[s] + 1;
      else    mdl[s] = (mdl[s] == 0) ? 0 : mdl[s] - 1;
      ghr = ((ghr << 1) | int'(rt)) & 3;
    end
  endtask

  // One cycle of the (1,1) instance with literal expectations.
  task automatic cyc1(input logic rv, input logic rh, input logic rt,
                      input int exp_p, input int exp_h);
    @(negedge clk);
    lk1_pc = 32'h0000_0040; rs1_valid = rv; rs1_pc = 32'h0000_0040;
    rs1_hist = rh; rs1_taken = rt;
    #1;
    check("R10", int'(pred1_taken), exp_p);
    check("R10", int'(pred1_hist), exp_h);
    @(posedge clk);
  endtask

  task automatic clear_hist();
    cyc(pc_of(9, 0), 1'b1, pc_of(9, 0), 3, 1'b0, "R7");
    cyc(pc_of(9, 0), 1'b1, pc_of(9, 0), 3, 1'b0, "R7");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] r1, r2;
    for (int i = 0; i < 64; i++) mdl[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: every row predicts not taken, history zero.
    for (int e = 0; e < 16; e++) cyc(pc_of(e, 0), 1'b0, '0, 0, 1'b0, "R1");

    // R10: (1,1) instance.
    cyc1(1'b0, 1'b0, 1'b0, 0, 0);
    cyc1(1'b1, 1'b0, 1'b1, 0, 0);
    cyc1(1'b1, 1'b1, 1'b0, 0, 1);
    cyc1(1'b1, 1'b0, 1'b0, 1, 0);
    cyc1(1'b0, 1'b0, 1'b0, 0, 0);

    // R3 R4 R6: sweep every row and column, returned history independent of live one.
    for (int pass = 0; pass < 4; pass++)
      for (int e = 0; e < 16; e++)
        for (int h = 0; h < 4; h++) begin
          next_rand(r1); next_rand(r2);
          cyc(pc_of(int'(r1[7:4]), r2), 1'b1, pc_of(e, r1), h, r2[3] ^ r1[9], "R6");
        end

    // R5: drive one counter to the top and past it.
    for (int k = 0; k < 6; k++) cyc(pc_of(5, 0), 1'b1, pc_of(5, 0), 0, 1'b1, "R5");
    clear_hist();
    cyc(pc_of(5, 0), 1'b1, pc_of(5, 0), 0, 1'b0, "R5");
    clear_hist();
    cyc(pc_of(5, 0), 1'b0, '0, 0, 1'b0, "R5");
    // Down to the floor and past it.
    for (int k = 0; k < 6; k++) cyc(pc_of(5, 0), 1'b1, pc_of(5, 0), 0, 1'b0, "R5");
    clear_hist();
    cyc(pc_of(5, 0), 1'b1, pc_of(5, 0), 0, 1'b1, "R5");
    clear_hist();
    cyc(pc_of(5, 0), 1'b0, '0, 0, 1'b0, "R5");

    // R2: aliased addresses differing only outside the row field.
    for (int e = 0; e < 16; e++) begin
      next_rand(r1);
      cyc(pc_of(e, r1), 1'b1, pc_of(e, ~r1), ghr, r1[2], "R2");
    end

    // R8: lookup of the very counter being resolved in the same cycle.
    clear_hist();
    cyc(pc_of(5, 0), 1'b1, pc_of(5, 32'hFF00_0001), 0, 1'b1, "R8");
    clear_hist();
    cyc(pc_of(5, 0), 1'b1, pc_of(5, 0), 0, 1'b1, "R8");
    cyc(pc_of(5, 0), 1'b1, pc_of(5, 0), 1, 1'b0, "R8");

    // R9: lookups only; nothing may move.
    for (int e = 0; e < 16; e++) begin
      next_rand(r1);
      cyc(pc_of(e, r1), 1'b0, pc_of(e, 0), 0, r1[0], "R9");
    end

    summary();
  end

endmodule